// File: doc/BRIEF.md
# Clock Failure Detector with Sticky Failover

This block supervises a primary clock that comes from off the chip. A free-running backup clock drives a small watchdog counter. Every edge of the primary clock, rising or falling, is brought into the backup domain and clears that counter. If the primary clock stays quiet for the whole count window, the block declares it dead. It then moves the system clock onto the backup source and raises an interrupt flag.

The switch to the backup source is one-way. Once the block fails over, it stays on the backup clock even if the primary clock starts toggling again, and even if software then turns the monitor off. Only reset brings the primary source back. The interrupt flag is separate from this state and can be cleared with a write-one-to-clear strobe.

When software turns the monitor off, the system clock is simply the primary clock. In that case the block also tells the backup oscillator that it may power down. The enable, disable and clear inputs are sampled on the backup clock. Reset is active-low and synchronous to the backup clock.

Top module: `clkmon_failover`

## Requirements
- R1: In the first cycle after reset releases, with `mon_dis` low, `sel_bak` is 0 (primary source), `fail_irq` is 0 and `bak_osc_en` is 1.
- R2: While the monitor is enabled, a primary clock whose transitions are never more than 14 backup cycles apart never causes a failover. This holds when each level lasts 14 backup cycles, so rising and falling edges must both clear the counter.
- R3: While the monitor is enabled, if the primary clock stops toggling, `sel_bak` stays 0 for at least 12 backup cycles after the stop. It becomes 1 no later than 24 backup cycles after the stop. The window is 16 backup cycles plus synchronizer latency.
- R4: `fail_irq` becomes 1 in the same backup clock cycle in which `sel_bak` becomes 1.
- R5: Once `sel_bak` is 1, it stays 1 while the primary clock runs again. Only reset returns it to 0.
- R6: Raising `mon_dis` after a failover leaves `sel_bak` at 1 and `bak_osc_en` at 1.
- R7: A one-cycle pulse of `irq_clr` (1 = clear) clears `fail_irq` and does not change `sel_bak`. The flag stays 0 afterwards while no new failure occurs.
- R8: While `mon_dis` is 1 and no failover has occurred, a stopped primary clock never causes a failover. `bak_osc_en` is 0 and `sys_clk` equals the primary clock.
- R9: Before a failover, `sys_clk` equals the primary clock once reset has been released for 20 backup cycles. No later than 6 backup cycles after `sel_bak` rises, `sys_clk` equals the backup clock.
- R10: The two clock gates are never open together. `sys_clk` is never the OR of both sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Primary clock under supervision |
| bak_clk | input | 1 | Free-running backup clock, clocks the detector |
| rst_n | input | 1 | Active-low reset, sampled on `bak_clk` |
| mon_dis | input | 1 | 1 = monitor off, 0 = monitor on (reset default) |
| irq_clr | input | 1 | Write-one-to-clear strobe for `fail_irq` |
| sel_bak | output | 1 | Source select state: 0 primary, 1 backup (sticky) |
| sys_clk | output | 1 | Glitch-free muxed system clock |
| fail_irq | output | 1 | Clock-failure interrupt request flag |
| bak_osc_en | output | 1 | Enable for the backup oscillator |

## Verification
The detector is driven with primary clocks of several toggle spacings: fast, moderately slow, just under the window with long levels of each polarity, just over the window, and fully stopped, each with the monitor on and off. The fast and slow cases show that no false trip occurs. The 14-cycle levels separate a counter cleared on both edges from one cleared on rising edges only. The 18-cycle levels and the stopped clock show that a real failure is detected. A directed sequence then restarts the primary clock after a failover, clears the flag and turns the monitor off, to show that the source select stays sticky independently of the flag. It also compares `sys_clk` against whichever source should be live.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    // Backup cycles without a primary transition that mean failure
    localparam int unsigned WDOG_TRIP_DEFAULT  = 16;
    // Flops in each clock-crossing synchronizer (at least 2)
    localparam int unsigned SYNC_DEPTH_DEFAULT = 2;

    typedef enum logic {
        SRC_PRI = 1'b0,
        SRC_BAK = 1'b1
    } clk_src_e;

    // Backup oscillator must run while monitoring or after failover
    function automatic logic osc_needed(input logic dis, input clk_src_e src);
        return (~dis) | (src == SRC_BAK);
    endfunction

endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic toggled
);
    logic [DEPTH:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[DEPTH-1:0], async_in};
    end

    // Either polarity of transition counts
    assign toggled = shreg[DEPTH] ^ shreg[DEPTH-1];
endmodule

// File: rtl/clkmon_wdog_ctr.sv
module clkmon_wdog_ctr #(
    parameter int unsigned TRIP = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    output logic trip
);
    localparam int unsigned CW = (TRIP > 2) ? $clog2(TRIP) : 1;
    localparam logic [CW-1:0] LAST = CW'(TRIP - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en || clr) cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    // Fires on the TRIP-th quiet cycle after the last clear
    assign trip = en & ~clr & (cnt == LAST);
endmodule

// File: rtl/clkmon_gf_mux.sv
module clkmon_gf_mux #(
    parameter int unsigned SYNC = 2
) (
    input  logic pri_clk,
    input  logic bak_clk,
    input  logic rst,
    input  logic want_bak,
    output logic pri_gate,
    output logic bak_gate,
    output logic sys_clk
);
    logic [SYNC-1:0] p_sync;
    logic [SYNC-1:0] b_sync;
    logic            kill;

    // A dead primary may never give a falling edge, so its gate is
    // forced shut; the detector has already seen it static.
    assign kill = rst | want_bak;

    always_ff @(negedge pri_clk or posedge kill) begin
        if (kill) begin
            p_sync   <= '0;
            pri_gate <= 1'b0;
        end else begin
            p_sync   <= {p_sync[SYNC-2:0], bak_gate};
            pri_gate <= ~p_sync[SYNC-1];
        end
    end

    always_ff @(negedge bak_clk) begin
        if (rst) begin
            b_sync   <= '0;
            bak_gate <= 1'b0;
        end else begin
            b_sync   <= {b_sync[SYNC-2:0], pri_gate};
            bak_gate <= want_bak & ~b_sync[SYNC-1];
        end
    end

    assign sys_clk = (pri_clk & pri_gate) | (bak_clk & bak_gate);
endmodule

// File: rtl/clkmon_failover.sv
module clkmon_failover
    import clkmon_pkg::*;
#(
    parameter int unsigned TRIP_CYCLES = WDOG_TRIP_DEFAULT,
    parameter int unsigned SYNC_DEPTH  = SYNC_DEPTH_DEFAULT
) (
    input  logic pri_clk,
    input  logic bak_clk,
    input  logic rst_n,
    input  logic mon_dis,
    input  logic irq_clr,
    output logic sel_bak,
    output logic sys_clk,
    output logic fail_irq,
    output logic bak_osc_en
);
    logic     rst;
    logic     pri_edge;
    logic     mon_active;
    logic     trip;
    logic     pri_gate;
    logic     bak_gate;
    clk_src_e src_q;

    assign rst        = ~rst_n;
    assign mon_active = ~mon_dis & (src_q == SRC_PRI);

    clkmon_edge_sync #(.DEPTH(SYNC_DEPTH)) u_edge (
        .clk      (bak_clk),
        .rst      (rst),
        .async_in (pri_clk),
        .toggled  (pri_edge)
    );

    clkmon_wdog_ctr #(.TRIP(TRIP_CYCLES)) u_ctr (
        .clk  (bak_clk),
        .rst  (rst),
        .en   (mon_active),
        .clr  (pri_edge),
        .trip (trip)
    );

    always_ff @(posedge bak_clk) begin
        if (rst) begin
            src_q    <= SRC_PRI;
            fail_irq <= 1'b0;
        end else begin
            if (trip) src_q <= SRC_BAK;
            if (trip)         fail_irq <= 1'b1;
            else if (irq_clr) fail_irq <= 1'b0;
        end
    end

    assign sel_bak    = (src_q == SRC_BAK);
    assign bak_osc_en = osc_needed(mon_dis, src_q);

    clkmon_gf_mux #(.SYNC(SYNC_DEPTH)) u_mux (
        .pri_clk  (pri_clk),
        .bak_clk  (bak_clk),
        .rst      (rst),
        .want_bak (sel_bak),
        .pri_gate (pri_gate),
        .bak_gate (bak_gate),
        .sys_clk  (sys_clk)
    );
endmodule

// File: rtl/clkmon_failover_chk.sv
module clkmon_failover_chk (
    input logic bak_clk,
    input logic rst_n,
    input logic mon_dis,
    input logic irq_clr,
    input logic sel_bak,
    input logic fail_irq,
    input logic bak_osc_en,
    input logic pri_gate,
    input logic bak_gate
);
    p_sticky_sel_r5: assert property (@(posedge bak_clk) disable iff (!rst_n)
        sel_bak |=> sel_bak);

    p_irq_with_fail_r4: assert property (@(posedge bak_clk) disable iff (!rst_n)
        $rose(sel_bak) |-> fail_irq);

    p_osc_kept_r6: assert property (@(posedge bak_clk) disable iff (!rst_n)
        sel_bak |-> bak_osc_en);

    p_osc_off_r8: assert property (@(posedge bak_clk) disable iff (!rst_n)
        (mon_dis && !sel_bak) |-> !bak_osc_en);

    p_no_trip_off_r8: assert property (@(posedge bak_clk) disable iff (!rst_n)
        (mon_dis && !sel_bak) |=> !sel_bak);

    p_irq_clear_r7: assert property (@(posedge bak_clk) disable iff (!rst_n)
        (irq_clr && sel_bak) |=> !fail_irq);

    p_gate_excl_r10: assert property (@(posedge bak_clk) disable iff (!rst_n)
        !(pri_gate && bak_gate));
endmodule

bind clkmon_failover clkmon_failover_chk u_chk (
    .bak_clk    (bak_clk),
    .rst_n      (rst_n),
    .mon_dis    (mon_dis),
    .irq_clr    (irq_clr),
    .sel_bak    (sel_bak),
    .fail_irq   (fail_irq),
    .bak_osc_en (bak_osc_en),
    .pri_gate   (pri_gate),
    .bak_gate   (bak_gate)
);

// File: tb/clkmon_failover_bench.sv
`timescale 1ns/1ps
module clkmon_failover_bench;
    logic pri_clk = 1'b0;
    logic bak_clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_dis = 1'b0;
    logic irq_clr = 1'b0;
    logic sel_bak, sys_clk, fail_irq, bak_osc_en;

    int  checks = 0;
    int  errors = 0;
    int  pri_half = 30;
    bit  pri_run = 1'b1;
    bit  done = 1'b0;

    clkmon_failover u_clkmon_failover (
        .pri_clk(pri_clk), .bak_clk(bak_clk), .rst_n(rst_n),
        .mon_dis(mon_dis), .irq_clr(irq_clr), .sel_bak(sel_bak),
        .sys_clk(sys_clk), .fail_irq(fail_irq), .bak_osc_en(bak_osc_en)
    );

    always #10 bak_clk = ~bak_clk;   // 50 MHz backup clock

    initial begin
        #7.3;
        forever begin
            if (pri_run) begin
                #(pri_half);
                pri_clk = ~pri_clk;
            end else #1;
        end
    end

    // half period ns, disable, stopped, expected failover
    typedef struct packed {
        logic [15:0] half;
        logic        dis;
        logic        stop;
        logic        exp_fail;
    } vec_t;
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd30,  1'b0, 1'b0, 1'b0},
        '{16'd150, 1'b0, 1'b0, 1'b0},
        '{16'd280, 1'b0, 1'b0, 1'b0},
        '{16'd360, 1'b0, 1'b0, 1'b1},
        '{16'd30,  1'b0, 1'b1, 1'b1},
        '{16'd30,  1'b1, 1'b1, 1'b0},
        '{16'd30,  1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge bak_clk);
        #5;
    endtask

    task automatic do_reset(input logic dis);
        pri_half = 30;
        pri_run  = 1'b1;
        mon_dis  = dis;
        irq_clr  = 1'b0;
        @(posedge bak_clk); #5;
        rst_n = 1'b0;
        cyc(5);
        rst_n = 1'b1;
    endtask

    // sys_clk must track pri_clk at instants where pri_clk is steady
    task automatic follow_pri(input string req);
        int cmp = 0;
        int bad = 0;
        for (int i = 0; i < 40; i++) begin
            logic p0, p1, p2, s;
            #3.7;
            p0 = pri_clk; #0.2; s = sys_clk; p1 = pri_clk; #0.2; p2 = pri_clk;
            if (p0 == p2) begin
                cmp++;
                if (s !== p1) bad++;
            end
        end
        chk(req, "sys_clk follows primary", (cmp >= 10) && (bad == 0), 1'b1);
    endtask

    task automatic follow_bak(input string req);
        int bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge bak_clk); #5;
            if (sys_clk !== 1'b1) bad++;
            @(negedge bak_clk); #5;
            if (sys_clk !== 1'b0) bad++;
        end
        chk(req, "sys_clk follows backup", bad == 0, 1'b1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #4ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // Table walk: R2, R3, R8
        for (int v = 0; v < NV; v++) begin
            do_reset(1'b0);
            cyc(20);
            mon_dis  = VECS[v].dis;
            pri_half = int'(VECS[v].half);
            if (VECS[v].stop) pri_run = 1'b0;
            cyc(80);
            chk(VECS[v].exp_fail ? "R3" : (VECS[v].dis ? "R8" : "R2"),
                $sformatf("vector %0d sel_bak", v), sel_bak, VECS[v].exp_fail);
            chk("R4", $sformatf("vector %0d fail_irq", v), fail_irq, VECS[v].exp_fail);
            chk("R8", $sformatf("vector %0d bak_osc_en", v), bak_osc_en,
                ~VECS[v].dis | VECS[v].exp_fail);
        end

        // R1 reset state
        do_reset(1'b0);
        cyc(1);
        chk("R1", "sel_bak after reset", sel_bak, 1'b0);
        chk("R1", "fail_irq after reset", fail_irq, 1'b0);
        chk("R1", "bak_osc_en after reset", bak_osc_en, 1'b1);
        cyc(20);
        follow_pri("R9/R10");

        // R3 timing window after a stop
        pri_run = 1'b0;
        cyc(12);
        chk("R3", "no trip 12 cycles after stop", sel_bak, 1'b0);
        cyc(12);
        chk("R3", "tripped by 24 cycles after stop", sel_bak, 1'b1);
        chk("R4", "flag set with failover", fail_irq, 1'b1);
        cyc(2);
        follow_bak("R9/R10");

        // R5 primary returns
        pri_run = 1'b1;
        cyc(40);
        chk("R5", "select sticky with primary back", sel_bak, 1'b1);
        follow_bak("R5");

        // R7 clear the flag
        irq_clr = 1'b1;
        cyc(1);
        irq_clr = 1'b0;
        chk("R7", "flag cleared", fail_irq, 1'b0);
        chk("R7", "select unchanged by clear", sel_bak, 1'b1);
        cyc(20);
        chk("R7", "flag stays clear", fail_irq, 1'b0);

        // R6 disable after failover
        mon_dis = 1'b1;
        cyc(10);
        chk("R6", "select sticky under disable", sel_bak, 1'b1);
        chk("R6", "oscillator kept on", bak_osc_en, 1'b1);

        // R5 reset returns to primary
        do_reset(1'b0);
        cyc(20);
        chk("R5", "reset returns primary", sel_bak, 1'b0);
        follow_pri("R5");

        // R8 disabled: primary passes through, stopped clock ignored
        do_reset(1'b1);
        cyc(20);
        follow_pri("R8");
        pri_run = 1'b0;
        cyc(60);
        chk("R8", "no trip while disabled", sel_bak, 1'b0);
        chk("R8", "oscillator off while disabled", bak_osc_en, 1'b0);
        mon_dis = 1'b0;
        cyc(24);
        chk("R3", "trip after re-enable with dead primary", sel_bak, 1'b1);

        done = 1'b1;
        finish_run();
    end
endmodule